// File: doc/BRIEF.md
# Beam-Break Missing-Pulse Alarm

This block guards an infrared light barrier. An upstream receiver demodulates the beam and pulls its output low for each carrier burst, which the far-end emitter sends every 10 ms. Every low level on that line restarts a prescaled countdown. When bursts stop arriving, for example because something is blocking the beam, the countdown runs out after about three missing bursts. The block then latches into an alarm state.

In the alarm state the block pulls an active-low alarm line low and drives a square wave to a piezo output. A duration counter is cleared once when the alarm starts and is not cleared again while the tone sounds. After about one second it performs a complete restart: the alarm line is released, the tone is silenced, and the longer start-up timeout is loaded again. A debug line gives a short low pulse each time a received burst is accepted.

All intervals are parameters. The defaults give a 1024-clock tick from a 3.6864 MHz clock, a 108-tick reload, a 120-tick first interval, a 690-clock tone half period and a 3686-tick alarm length.

Top module: `irbeam_guard`

## Requirements
- R1: While reset is asserted and right after it is released, `alarm_n` is 1, `tone` is 0 and `dbg_n` is 1.
- R2: If no burst arrives after reset, `alarm_n` goes low exactly FIRST_TICKS x PRESCALE clocks after reset release. The tick fires on every PRESCALE-th clock, counted from reset release.
- R3: `rx_n` is active low and level-sensitive. Each clock in which it is low is seen after a two-flop synchronizer and reloads the countdown to RELOAD_TICKS. Bursts spaced well inside that window keep `alarm_n` high.
- R4: If no burst arrives for more than RELOAD_TICKS ticks after the last accepted one, the countdown expires and `alarm_n` goes low.
- R5: Once the alarm has started, `alarm_n` stays low. Low levels on `rx_n` have no effect: they neither end the alarm, nor pulse `dbg_n`, nor lengthen the alarm.
- R6: `tone` is 0 outside the alarm. Inside the alarm it first rises TONE_HALF clocks after alarm entry and then toggles every TONE_HALF clocks.
- R7: The alarm lasts exactly WDOG_TICKS ticks (WDOG_TICKS x PRESCALE clocks). The block then restarts with `alarm_n` 1, `tone` 0 and `dbg_n` 1.
- R8: After a restart the first countdown is FIRST_TICKS again, so `alarm_n` falls FIRST_TICKS x PRESCALE clocks after the restart edge if no burst arrives.
- R9: `dbg_n` goes low on the third clock edge after `rx_n` falls. It returns high PRESCALE clocks after the last accepted low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_n | input | 1 | Demodulated receiver line, low while a burst is present |
| tone | output | 1 | Square wave to the piezo driver, low when silent |
| alarm_n | output | 1 | Alarm line, low while the alarm is active |
| dbg_n | output | 1 | Low pulse for each accepted burst |

## Verification
Bursts are applied with gaps well inside the reload window and with gaps well past it. This separates the case where the reload holds off the alarm from the case where it expires. A run with no bursts at all, both from reset and after a watchdog restart, measures the first interval exactly, which separates the start-up length from the reload length. Inside the alarm, the tone edges and the alarm duration are counted, and a burst is injected to show that it neither clears the duration count nor pulses the debug line. A single short burst in the idle state checks the exact latency and width of the debug pulse.

// File: rtl/irbeam_pkg.sv
package irbeam_pkg;
   typedef enum logic {
      ST_WATCH = 1'b0,
      ST_ALARM = 1'b1
   } beam_state_e;
endpackage

// File: rtl/irbeam_sync.sv
module irbeam_sync #(
   parameter int  STAGES    = 2,
   parameter bit  RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("irbeam_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= RESET_VAL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/irbeam_tick.sv
module irbeam_tick #(
   parameter int DIV = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("irbeam_tick: DIV must be at least 2");
      end
   endgenerate

   logic [PW-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre_q <= '0;
      else if (clr)            pre_q <= '0;
      else if (pre_q == LAST)  pre_q <= '0;
      else                     pre_q <= pre_q + PW'(1);
   end

   assign tick = (pre_q == LAST);
endmodule

// File: rtl/irbeam_tone.sv
module irbeam_tone #(
   parameter int HALF = 690
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tone
);
   localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   generate
      if (HALF < 2) begin : g_bad_half
         $error("irbeam_tone: HALF must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tone  <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         tone  <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
         tone  <= ~tone;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/irbeam_guard.sv
module irbeam_guard
   import irbeam_pkg::*;
#(
   parameter int PRESCALE     = 1024,
   parameter int RELOAD_TICKS = 108,
   parameter int FIRST_TICKS  = 120,
   parameter int TONE_HALF    = 690,
   parameter int WDOG_TICKS   = 3686,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_n,
   output logic tone,
   output logic alarm_n,
   output logic dbg_n
);
   localparam int TMO_MAX = (FIRST_TICKS > RELOAD_TICKS) ? FIRST_TICKS : RELOAD_TICKS;
   localparam int TMO_W   = $clog2(TMO_MAX + 1);
   localparam int WD_W    = $clog2(WDOG_TICKS + 1);
   localparam int DH_W    = $clog2(PRESCALE + 1);

   generate
      if (RELOAD_TICKS < 1 || FIRST_TICKS < 1) begin : g_bad_tmo
         $error("irbeam_guard: timeout lengths must be at least 1 tick");
      end
      if (WDOG_TICKS < 1) begin : g_bad_wdog
         $error("irbeam_guard: WDOG_TICKS must be at least 1");
      end
   endgenerate

   logic              rx_s;
   logic              pulse;
   logic              tick;
   logic              restart;
   logic              tone_en;
   beam_state_e       st_q;
   logic [TMO_W-1:0]  tmo_q;
   logic [WD_W-1:0]   wd_q;
   logic [DH_W-1:0]   dh_q;

   irbeam_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_n),
      .q_out (rx_s)
   );

   assign pulse   = ~rx_s;
   assign restart = (st_q == ST_ALARM) && tick && (wd_q == WD_W'(WDOG_TICKS - 1));
   assign tone_en = (st_q == ST_ALARM) && !restart;

   irbeam_tick #(.DIV(PRESCALE)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .tick  (tick)
   );

   irbeam_tone #(.HALF(TONE_HALF)) u_tone (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tone_en),
      .tone  (tone)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_WATCH;
         tmo_q <= TMO_W'(FIRST_TICKS);
         wd_q  <= '0;
         dh_q  <= '0;
      end else begin
         if (dh_q != '0) dh_q <= dh_q - DH_W'(1);
         case (st_q)
            ST_WATCH: begin
               if (pulse) begin
                  tmo_q <= TMO_W'(RELOAD_TICKS);
                  wd_q  <= '0;
                  dh_q  <= DH_W'(PRESCALE);
               end else if (tick) begin
                  if (tmo_q == TMO_W'(1)) begin
                     st_q <= ST_ALARM;
                     wd_q <= '0;
                  end else begin
                     tmo_q <= tmo_q - TMO_W'(1);
                  end
               end
            end
            ST_ALARM: begin
               if (restart) begin
                  st_q  <= ST_WATCH;
                  tmo_q <= TMO_W'(FIRST_TICKS);
                  wd_q  <= '0;
                  dh_q  <= '0;
               end else if (tick) begin
                  wd_q <= wd_q + WD_W'(1);
               end
            end
            default: st_q <= ST_WATCH;
         endcase
      end
   end

   assign alarm_n = (st_q != ST_ALARM);
   assign dbg_n   = (dh_q == '0);
endmodule

// File: rtl/irbeam_guard_chk.sv
module irbeam_guard_chk #(
   parameter int RELOAD_TICKS = 108,
   parameter int WDOG_TICKS   = 3686,
   parameter int TMO_W        = 8,
   parameter int WD_W         = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alarm_n,
   input logic             tone,
   input logic             dbg_n,
   input logic             tick,
   input logic             pulse,
   input logic [TMO_W-1:0] tmo_q,
   input logic [WD_W-1:0]  wd_q
);
   a_r6_tone_idle: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_n |-> !tone);

   a_r2_entry_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alarm_n) |-> $past(tick));

   a_r7_exit_on_wdog: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_n) |-> ($past(tick) && $past(wd_q) == WD_W'(WDOG_TICKS - 1)));

   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_n && pulse) |=> (tmo_q == TMO_W'(RELOAD_TICKS)));

   a_r4_pulse_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_n && pulse) |=> alarm_n);

   a_r5_alarm_ignores_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_n && !tick) |=> !alarm_n);

   a_r9_dbg_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_n && pulse) |=> !dbg_n);
endmodule

bind irbeam_guard irbeam_guard_chk #(
   .RELOAD_TICKS (RELOAD_TICKS),
   .WDOG_TICKS   (WDOG_TICKS),
   .TMO_W        (TMO_W),
   .WD_W         (WD_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .alarm_n (alarm_n),
   .tone    (tone),
   .dbg_n   (dbg_n),
   .tick    (tick),
   .pulse   (pulse),
   .tmo_q   (tmo_q),
   .wd_q    (wd_q)
);

// File: tb/irbeam_guard_bench.sv
`timescale 1ns/1ps
module irbeam_guard_bench;
   localparam int P     = 4;
   localparam int RLD   = 6;
   localparam int FST   = 8;
   localparam int HALF  = 3;
   localparam int WDOG  = 10;
   localparam int NVEC  = 6;
   // gap in clocks after a one-clock burst, expected alarm (1) or not (0)
   localparam int VEC [NVEC][2] = '{'{5,0}, '{12,0}, '{8,0}, '{30,1}, '{10,0}, '{40,1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_n = 1'b1;
   logic tone, alarm_n, dbg_n;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   irbeam_guard #(
      .PRESCALE(P), .RELOAD_TICKS(RLD), .FIRST_TICKS(FST),
      .TONE_HALF(HALF), .WDOG_TICKS(WDOG), .SYNC_STAGES(2)
   ) u_irbeam_guard (
      .clk(clk), .rst_n(rst_n), .rx_n(rx_n),
      .tone(tone), .alarm_n(alarm_n), .dbg_n(dbg_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rx_n  = 1'b1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int cnt, lowcnt, first_rise, toggles;
      bit prev_tone, dbg_seen_low;
      // R1: reset values
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(alarm_n == 1'b1, "R1 alarm_n in reset", alarm_n, 1);
      check(tone == 1'b0,    "R1 tone in reset", tone, 0);
      check(dbg_n == 1'b1,   "R1 dbg_n in reset", dbg_n, 1);
      rst_n = 1'b1;

      // R2: first interval from reset release
      cnt = 0;
      @(negedge clk);
      while (alarm_n && cnt < 1000) begin cnt++; @(negedge clk); end
      check(cnt == FST*P - 1, "R2 first timeout samples", cnt, FST*P - 1);

      // R5/R6/R7: alarm body, with a burst injected part way
      lowcnt = 0; first_rise = -1; toggles = 0; prev_tone = tone; dbg_seen_low = 1'b0;
      while (!alarm_n && lowcnt < 1000) begin
         lowcnt++;
         if (tone != prev_tone) toggles++;
         if (tone && first_rise < 0) first_rise = lowcnt - 1;
         if (!dbg_n) dbg_seen_low = 1'b1;
         prev_tone = tone;
         rx_n = !(lowcnt >= 10 && lowcnt < 12);
         @(negedge clk);
      end
      check(first_rise == HALF, "R6 clocks to first tone rise", first_rise, HALF);
      check(toggles == (WDOG*P - 1)/HALF, "R6 tone toggles in alarm", toggles, (WDOG*P - 1)/HALF);
      check(lowcnt == WDOG*P, "R7 R5 alarm length despite burst", lowcnt, WDOG*P);
      check(dbg_seen_low == 1'b0, "R5 dbg_n stays high in alarm", dbg_seen_low, 0);
      check(tone == 1'b0 && dbg_n == 1'b1, "R7 tone/dbg after restart", {tone, dbg_n}, 1);

      // R8: restart reloads the first interval
      cnt = 0;
      while (alarm_n && cnt < 1000) begin cnt++; @(negedge clk); end
      check(cnt == FST*P, "R8 first timeout after restart", cnt, FST*P);

      // R9: debug pulse latency and width
      do_reset();
      repeat (5) @(negedge clk);
      rx_n = 1'b0;
      @(negedge clk); rx_n = 1'b1;
      check(dbg_n == 1'b1, "R9 dbg_n before sync latency", dbg_n, 1);
      @(negedge clk);
      @(negedge clk);
      check(dbg_n == 1'b0, "R9 dbg_n low on third edge", dbg_n, 0);
      repeat (P - 1) @(negedge clk);
      check(dbg_n == 1'b0, "R9 dbg_n still low at end", dbg_n, 0);
      @(negedge clk);
      check(dbg_n == 1'b1, "R9 dbg_n back high", dbg_n, 1);

      // R3/R4: gap table
      do_reset();
      for (int i = 0; i < NVEC; i++) begin
         bit seen;
         seen = 1'b0;
         rx_n = 1'b0;
         @(negedge clk);
         rx_n = 1'b1;
         for (int k = 0; k < VEC[i][0]; k++) begin
            @(negedge clk);
            if (!alarm_n) seen = 1'b1;
         end
         if (VEC[i][1] != 0)
            check(seen == 1'b1, "R4 alarm after long gap", seen, 1);
         else
            check(seen == 1'b0, "R3 no alarm with short gap", seen, 0);
         if (seen) do_reset();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule